// File: doc/BRIEF.md
# Banked Output-Enable I/O Cells

This block is the pad side of one logic block: twelve I/O cells that take the twelve macrocell results and place them on bidirectional pins. Each pin has a three-state buffer. Every cell has its own 2-bit mode that sets where the buffer enable comes from. The mode can hold the buffer on, hold it off, or follow one of two shared enable terms.

The cells are split into two banks of six. Each bank has a pair of enable terms that only its own cells can use. The four terms are computed elsewhere and arrive on `oe_term`: bits 0 and 1 belong to the low bank (cells 0 to 5), and bits 2 and 3 belong to the high bank (cells 6 to 11). Every pin also returns its resolved level on `pad_fb` to the routing. When a pin's buffer is off, an external driver can use that pin as an input.

The block is purely combinational. Mode fields live in `cell_mode`, with cell i at bits [2i+1:2i].

Top module: `banked_io_cells`

## Requirements
- R1: Mode 2'b00 disables the buffer of that cell: `pad_oe[i]` is 0 and the block leaves `pad[i]` at high impedance.
- R2: Mode 2'b01 enables the buffer of that cell whatever the enable terms are.
- R3: Mode 2'b10 makes `pad_oe[i]` follow the first term of the cell's bank: `oe_term[0]` for cells 0 to 5, `oe_term[2]` for cells 6 to 11.
- R4: Mode 2'b11 makes `pad_oe[i]` follow the second term of the cell's bank: `oe_term[1]` for cells 0 to 5, `oe_term[3]` for cells 6 to 11.
- R5: Terms 2 and 3 have no effect on the enables of cells 0 to 5, and terms 0 and 1 have no effect on the enables of cells 6 to 11.
- R6: `pad_drv` always equals `cell_out`, whether or not the buffer is enabled.
- R7: While a cell's buffer is enabled, `pad[i]` and `pad_fb[i]` carry `cell_out[i]`.
- R8: While a cell's buffer is disabled, `pad_fb[i]` shows the level an external source drives onto `pad[i]`.
- R9: Each cell's enable depends only on its own mode field and its bank's terms. Other cells' modes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cell_out | input | 12 | Macrocell results, one per cell |
| oe_term | input | 4 | Shared enable terms: [1:0] low bank, [3:2] high bank |
| cell_mode | input | 24 | Per-cell enable mode, cell i at [2i+1:2i] |
| pad_drv | output | 12 | Value each buffer drives when enabled |
| pad_oe | output | 12 | Per-pin buffer enable |
| pad | inout | 12 | Bidirectional pins |
| pad_fb | output | 12 | Resolved pin level returned to the routing |

## Verification
The checker evaluates the enable decode for all four modes on every input change, and confirms that an enabled pin returns the macrocell value on its feedback. Bank isolation, per-cell independence, and the use of a disabled pin as an input cannot be seen from a single evaluation. The bench scenarios show these: they sweep one bank's terms while holding the other bank fixed, mix modes across the cells, and drive the disabled pins from outside.

// File: rtl/bio_pkg.sv
package bio_pkg;

  // Enable source selected per cell
  typedef enum logic [1:0] {
    OE_OFF    = 2'b00,
    OE_ON     = 2'b01,
    OE_TERM_A = 2'b10,
    OE_TERM_B = 2'b11
  } oe_mode_e;

  localparam int MODE_W         = 2;
  localparam int TERMS_PER_BANK = 2;

endpackage

// File: rtl/cell_oe_sel.sv
module cell_oe_sel
  import bio_pkg::*;
(
  input  logic [MODE_W-1:0]         mode,
  input  logic [TERMS_PER_BANK-1:0] bank_terms,
  output logic                      oe
);

  always_comb begin
    case (oe_mode_e'(mode))
      OE_OFF:    oe = 1'b0;
      OE_ON:     oe = 1'b1;
      OE_TERM_A: oe = bank_terms[0];
      OE_TERM_B: oe = bank_terms[1];
      default:   oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/io_bank.sv
module io_bank
  import bio_pkg::*;
#(
  parameter int BANK_SIZE = 6
) (
  input  logic [BANK_SIZE*MODE_W-1:0] modes,
  input  logic [TERMS_PER_BANK-1:0]   terms,
  output logic [BANK_SIZE-1:0]        oe
);

  for (genvar c = 0; c < BANK_SIZE; c++) begin : g_cell
    cell_oe_sel i_sel (
      .mode       (modes[c*MODE_W +: MODE_W]),
      .bank_terms (terms),
      .oe         (oe[c])
    );
  end

endmodule

// File: rtl/banked_io_cells.sv
module banked_io_cells
  import bio_pkg::*;
#(
  parameter int NUM_CELLS = 12,
  parameter int BANK_SIZE = 6,
  localparam int NUM_BANKS = NUM_CELLS / BANK_SIZE,
  localparam int NUM_TERMS = NUM_BANKS * TERMS_PER_BANK,
  localparam int CFG_W     = NUM_CELLS * MODE_W
) (
  input  logic [NUM_CELLS-1:0] cell_out,
  input  logic [NUM_TERMS-1:0] oe_term,
  input  logic [CFG_W-1:0]     cell_mode,
  output logic [NUM_CELLS-1:0] pad_drv,
  output logic [NUM_CELLS-1:0] pad_oe,
  inout  wire  [NUM_CELLS-1:0] pad,
  output logic [NUM_CELLS-1:0] pad_fb
);

  localparam int BANK_CFG_W = BANK_SIZE * MODE_W;

  // Enable decode: each bank sees only its own pair of terms
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    io_bank #(.BANK_SIZE(BANK_SIZE)) i_bank (
      .modes (cell_mode[b*BANK_CFG_W +: BANK_CFG_W]),
      .terms (oe_term[b*TERMS_PER_BANK +: TERMS_PER_BANK]),
      .oe    (pad_oe[b*BANK_SIZE +: BANK_SIZE])
    );
  end

  assign pad_drv = cell_out;

  // Three-state pin drivers
  for (genvar p = 0; p < NUM_CELLS; p++) begin : g_pad
    assign pad[p] = pad_oe[p] ? pad_drv[p] : 1'bz;
  end

  // Resolved pin level back into routing
  assign pad_fb = pad;

endmodule

// File: rtl/banked_io_cells_chk.sv
module banked_io_cells_chk #(
  parameter int NUM_CELLS = 12,
  parameter int BANK_SIZE = 6,
  localparam int NUM_TERMS = (NUM_CELLS / BANK_SIZE) * 2,
  localparam int CFG_W     = NUM_CELLS * 2
) (
  input logic [NUM_CELLS-1:0] cell_out,
  input logic [NUM_TERMS-1:0] oe_term,
  input logic [CFG_W-1:0]     cell_mode,
  input logic [NUM_CELLS-1:0] pad_oe,
  input logic [NUM_CELLS-1:0] pad_fb
);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    localparam int TA = (i / BANK_SIZE) * 2;
    always_comb begin
      if (!$isunknown({cell_mode, oe_term, cell_out})) begin
        // R1
        if (cell_mode[2*i +: 2] == 2'b00)
          mode_off_chk: assert (pad_oe[i] == 1'b0);
        // R2
        if (cell_mode[2*i +: 2] == 2'b01)
          mode_on_chk: assert (pad_oe[i] == 1'b1);
        // R3
        if (cell_mode[2*i +: 2] == 2'b10)
          term_a_chk: assert (pad_oe[i] == oe_term[TA]);
        // R4
        if (cell_mode[2*i +: 2] == 2'b11)
          term_b_chk: assert (pad_oe[i] == oe_term[TA+1]);
        // R7
        if (pad_oe[i])
          drive_fb_chk: assert (pad_fb[i] == cell_out[i]);
      end
    end
  end

endmodule

bind banked_io_cells banked_io_cells_chk #(
  .NUM_CELLS (NUM_CELLS),
  .BANK_SIZE (BANK_SIZE)
) i_chk (
  .cell_out  (cell_out),
  .oe_term   (oe_term),
  .cell_mode (cell_mode),
  .pad_oe    (pad_oe),
  .pad_fb    (pad_fb)
);

// File: tb/test_banked_io_cells.sv
module test_banked_io_cells;

  logic        clk;
  logic        rst_n;
  logic [11:0] cell_out;
  logic [3:0]  oe_term;
  logic [23:0] cell_mode;
  logic [11:0] pad_drv, pad_oe, pad_fb;
  wire  [11:0] pad;
  logic [11:0] ext_val, ext_en;
  int checks, errors;

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  for (genvar p = 0; p < 12; p++) begin : g_ext
    assign pad[p] = ext_en[p] ? ext_val[p] : 1'bz;
  end

  banked_io_cells i_banked_io_cells (
    .cell_out (cell_out),
    .oe_term  (oe_term),
    .cell_mode(cell_mode),
    .pad_drv  (pad_drv),
    .pad_oe   (pad_oe),
    .pad      (pad),
    .pad_fb   (pad_fb)
  );

  // Expected enables from the mode encoding (R1-R4 rules, bank split at 6)
  function automatic logic [11:0] exp_oe(input logic [23:0] m, input logic [3:0] t);
    logic [11:0] r;
    for (int i = 0; i < 12; i++) begin
      int base;
      base = (i < 6) ? 0 : 2;
      case (m[2*i +: 2])
        2'b00: r[i] = 1'b0;
        2'b01: r[i] = 1'b1;
        2'b10: r[i] = t[base];
        default: r[i] = t[base+1];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Apply on the rising edge, sample on the falling edge
  task automatic apply(input logic [11:0] co, input logic [3:0] t,
                       input logic [23:0] m, input logic [11:0] ev);
    @(posedge clk);
    cell_out  = co;
    oe_term   = t;
    cell_mode = m;
    ext_val   = ev;
    ext_en    = ~exp_oe(m, t);
    @(negedge clk);
  endtask

  task automatic t_idle;
    @(posedge clk);
    ext_en = 12'h000; cell_out = 12'hFFF; oe_term = 4'hF; cell_mode = 24'h0;
    @(negedge clk);
    chk("R1 all off enables", pad_oe, 12'h000);
    chk("R1 pins released", pad_fb, 12'hzzz);
    apply(12'hFFF, 4'hF, 24'h0, 12'hA5C);
    chk("R8 external input on off pins", pad_fb, 12'hA5C);
  endtask

  task automatic t_always_on;
    apply(12'h3C5, 4'h0, 24'h555555, 12'h000);
    chk("R2 all on enables", pad_oe, 12'hFFF);
    chk("R7 feedback of driven pins", pad_fb, 12'h3C5);
    chk("R6 drive value", pad_drv, 12'h3C5);
    apply(12'hC3A, 4'hF, 24'h555555, 12'h000);
    chk("R7 feedback after change", pad_fb, 12'hC3A);
    apply(12'h5A5, 4'hF, 24'h0, 12'h0F0);
    chk("R6 drive value while disabled", pad_drv, 12'h5A5);
  endtask

  task automatic t_terms;
    for (int t = 0; t < 16; t++) begin
      apply(12'h9B6, 4'(t), 24'hAAAAAA, 12'h000);
      chk("R3 first bank term", pad_oe, exp_oe(24'hAAAAAA, 4'(t)));
      apply(12'h9B6, 4'(t), 24'hFFFFFF, 12'h000);
      chk("R4 second bank term", pad_oe, exp_oe(24'hFFFFFF, 4'(t)));
    end
    apply(12'h000, 4'b0110, 24'hAAAAAA, 12'h000);
    chk("R3 fixed case", pad_oe, 12'hFC0);
    apply(12'h000, 4'b0110, 24'hFFFFFF, 12'h000);
    chk("R4 fixed case", pad_oe, 12'h03F);
  endtask

  task automatic t_isolation;
    // low bank on terms, high bank off: sweep high terms only
    for (int t = 0; t < 4; t++) begin
      apply(12'h000, {2'(t), 2'b01}, 24'h000_ABE, 12'hFFF);
      chk("R5 low bank ignores high terms", pad_oe & 12'h03F, 12'h03F & exp_oe(24'h000_ABE, 4'b0001));
      chk("R5 low bank pins", pad_fb & 12'h03F, 12'h03F & (12'hFFF & ~exp_oe(24'h000_ABE, 4'b0001)));
    end
    for (int t = 0; t < 4; t++) begin
      apply(12'h000, {2'b10, 2'(t)}, 24'hBEA_000, 12'hFFF);
      chk("R5 high bank ignores low terms", pad_oe & 12'hFC0, 12'hFC0 & exp_oe(24'hBEA_000, 4'b1000));
    end
  endtask

  task automatic t_mixed;
    logic [23:0] pats [4];
    pats[0] = 24'h1B1B1B; pats[1] = 24'hE4E4E4;
    pats[2] = 24'h6C3972; pats[3] = 24'h0F5AC3;
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 16; t += 5) begin
        logic [11:0] eo;
        eo = exp_oe(pats[p], 4'(t));
        apply(12'h6D2 ^ 12'(p*291), 4'(t), pats[p], 12'h1E7 ^ 12'(t*77));
        chk("R9 mixed modes enables", pad_oe, eo);
        chk("R7 R8 mixed pin feedback", pad_fb,
            (eo & (12'h6D2 ^ 12'(p*291))) | (~eo & (12'h1E7 ^ 12'(t*77))));
      end
    end
    // Change only cell 0's mode: all other enables must hold
    apply(12'h000, 4'h5, 24'hAAAAA9, 12'h000);
    chk("R9 before single change", pad_oe, exp_oe(24'hAAAAA9, 4'h5));
    apply(12'h000, 4'h5, 24'hAAAAA8, 12'h000);
    chk("R9 others unchanged", pad_oe & 12'hFFE, exp_oe(24'hAAAAA9, 4'h5) & 12'hFFE);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    ext_en = 12'h000; ext_val = 12'h000;
    cell_out = 12'h000; oe_term = 4'h0; cell_mode = 24'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_always_on();
    t_terms();
    t_isolation();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule